// File: doc/BRIEF.md
# SPI-Attached Asynchronous Serial Port

This block is a slave peripheral. It places one asynchronous serial transmitter/receiver pair behind a 16-bit full-duplex SPI word interface. The master frames each transaction with an active-low select. Over the frame it shifts in a 16-bit word, most significant bit first. In the same bit periods it shifts out a 16-bit reply. The two top bits of the incoming word pick one of four operations: write the setup register, read the setup register, write a character to transmit, or read a received character. The reply always leads with two live flags, "character waiting" and "transmitter can take a byte". The rest of the reply depends on the command.

All logic runs from one reference clock (nominally 3.6864 MHz). The SPI pins are oversampled on this clock, so the SPI bit rate must stay well below it. The same clock feeds a baud divider that produces a 16x oversampling tick. A 4-bit code in the setup register selects the divider. Frame shape is also set there: 7 or 8 data bits, an optional extra (parity) bit, and one or two stop bits. The transmitter has a one-byte holding register ahead of its shifter. The receiver has a single result register that the master empties by issuing data frames.

Top module: `spi_uart`

## Requirements
- R1: A transaction counts only when exactly 16 rising SPI clock edges occur while select is low. The select rising edge ends the transaction. Shorter or longer frames change no state.
- R2: Command bits 15:14 are decoded as follows: 11 stores bits 13:0 as the setup word, 01 reads it, 10 writes data and 00 reads data. Setup reads and setup writes both return the stored setup word in reply bits 13:0. A setup read leaves the stored word unchanged. Setup bit 4 set means 7 data bits, bit 5 enables the extra bit, bit 6 selects two stop bits, and bits 3:0 hold the baud code.
- R3: Reply bit 15 shows whether a received character is waiting, and bit 14 shows whether the holding register is empty. Both are sampled when select falls.
- R4: A data write with bit 10 low queues bits 8:0 into the holding register if it is empty. The write is dropped if the register is full or bit 10 is high. A data write also returns the pending received character in bits 7:0.
- R5: After any complete data write, the rts_n pin equals the inverse of bit 9 of that write.
- R6: A data read returns the character in bits 7:0, the received extra bit in bit 8, the inverse of the cts_n pin in bit 9, the framing-error flag in bit 10, and zeros in bits 13:11.
- R7: Any data frame that began with bit 15 set clears the waiting flag, unless a newer character arrived during that frame. A character that completes while one is already waiting overwrites it, and the flag stays set.
- R8: One serial bit lasts 16 times the divider in reference cycles. Codes 0, 1, 2, 9, 10, 11, 12, 13, 14 and 15 give dividers 1, 2, 4, 6, 12, 24, 48, 96, 192 and 384. Codes 3 to 8 use divider 2.
- R9: A serial frame goes out as one low start bit, then the data bits least significant first, then bit 8 if the extra bit is enabled, then one or two high stop bits. txd rests high when idle.
- R10: The receiver confirms the start bit at mid-bit and samples each later bit at mid-bit. A low first stop bit sets the framing-error flag reported with that character.
- R11: After reset, the setup word is zero, neither flag shows a waiting character, the holding register is empty, and txd and rts_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI select, active low, frames a word |
| sclk | input | 1 | SPI clock, idle low, data taken on rising edge |
| mosi | input | 1 | SPI data from master |
| miso | output | 1 | SPI reply data, changes after falling edge |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rts_n | output | 1 | Request-to-send, active low |
| cts_n | input | 1 | Clear-to-send, active low |

## Verification
The per-cycle checks cover the following: a new serial frame always opens with a low line, the setup word and rts_n change only in the cycle after a complete frame, the waiting flag rises only on a validated stop-bit sample, and a full holding register empties as soon as the shifter is free. Only the bench scenarios can show the end-to-end results. These are the exact bit order and length of transmitted frames, the bit time for each divider, the overwrite and clear behaviour of the receive register, and the drop of a write aimed at a full holding register. They also include the rejection of short frames.

// File: rtl/spi_uart.sv
module spi_uart (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic miso,
  output logic txd,
  input  logic rxd,
  output logic rts_n,
  input  logic cts_n
);
  logic [2:0] cs_q, sck_q;
  logic [1:0] mo_q, rx_q, ct_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= '1; sck_q <= '0; mo_q <= '0; rx_q <= '1; ct_q <= '1;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sclk};
      mo_q  <= {mo_q[0], mosi};
      rx_q  <= {rx_q[0], rxd};
      ct_q  <= {ct_q[0], cts_n};
    end

  wire cs_fall  = cs_q[2] & ~cs_q[1];
  wire cs_rise  = ~cs_q[2] & cs_q[1];
  wire sck_rise = ~cs_q[1] & ~sck_q[2] & sck_q[1];
  wire sck_fall = ~cs_q[1] & sck_q[2] & ~sck_q[1];

  logic [15:0] rx_sh, resp;
  logic [4:0]  nbit;
  logic [3:0]  oidx;
  logic [13:0] cfg;
  logic        r_flag, thr_full, fresh;
  logic [7:0]  rx_data;
  logic        rx_par, rx_fe;

  wire [1:0] cmd      = rx_sh[15:14];
  wire       frame_ok = cs_rise && nbit == 5'd16;
  wire       wr_data  = frame_ok && cmd == 2'b10 && !rx_sh[10];
  wire       rd_ack   = frame_ok && !cmd[0] && resp[15];

  assign miso = resp[~oidx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sh <= '0; resp <= '0; nbit <= '0; oidx <= '0; cfg <= '0; rts_n <= 1'b1;
    end else begin
      if (cs_fall) begin
        nbit <= '0;
        oidx <= '0;
        resp <= {r_flag, ~thr_full, 14'd0};
      end
      if (sck_rise) begin
        rx_sh <= {rx_sh[14:0], mo_q[1]};
        if (nbit != 5'd17) nbit <= nbit + 5'd1;
        if (nbit == 5'd1)
          resp[13:0] <= mo_q[1] ? cfg : {3'b000, rx_fe, ~ct_q[1], rx_par, rx_data};
      end
      if (sck_fall) oidx <= oidx + 4'd1;
      if (frame_ok && cmd == 2'b11) cfg <= rx_sh[13:0];
      if (frame_ok && cmd == 2'b10) rts_n <= ~rx_sh[9];
    end

  logic [8:0] div, bcnt;
  always_comb
    case (cfg[3:0])
      4'd0:  div = 9'd1;
      4'd1:  div = 9'd2;
      4'd2:  div = 9'd4;
      4'd9:  div = 9'd6;
      4'd10: div = 9'd12;
      4'd11: div = 9'd24;
      4'd12: div = 9'd48;
      4'd13: div = 9'd96;
      4'd14: div = 9'd192;
      4'd15: div = 9'd384;
      default: div = 9'd2;
    endcase

  wire tick = bcnt >= div - 9'd1;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= tick ? 9'd0 : bcnt + 9'd1;

  wire [3:0] nd  = cfg[4] ? 4'd7 : 4'd8;
  wire       pe  = cfg[5];
  wire       st2 = cfg[6];

  logic [8:0]  thr;
  logic        tx_busy;
  logic [11:0] tx_sh, tx_frame;
  logic [3:0]  tx_left, tx_sub;

  always_comb begin
    tx_frame    = '1;
    tx_frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(nd)) tx_frame[i+1] = thr[i];
    if (pe) tx_frame[nd + 4'd1] = thr[8];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      thr <= '0; thr_full <= 1'b0; tx_busy <= 1'b0; tx_sh <= '1;
      tx_left <= '0; tx_sub <= '0; txd <= 1'b1;
    end else if (!tx_busy && thr_full) begin
      tx_sh    <= tx_frame;
      tx_left  <= 4'd2 + nd + {3'b000, pe} + {3'b000, st2};
      tx_sub   <= '0;
      tx_busy  <= 1'b1;
      thr_full <= 1'b0;
      txd      <= tx_frame[0];
    end else begin
      if (wr_data && !thr_full) begin
        thr      <= rx_sh[8:0];
        thr_full <= 1'b1;
      end
      if (tx_busy && tick) begin
        tx_sub <= tx_sub + 4'd1;
        if (tx_sub == 4'd15) begin
          tx_sh   <= {1'b1, tx_sh[11:1]};
          tx_left <= tx_left - 4'd1;
          if (tx_left == 4'd1) begin
            tx_busy <= 1'b0;
            txd     <= 1'b1;
          end else txd <= tx_sh[1];
        end
      end
    end

  logic       rx_act, rx_pb;
  logic [3:0] rx_sub, rx_idx;
  logic [7:0] rx_buf;
  wire        rxs     = rx_q[1];
  wire [3:0]  stop_k  = nd + {3'b000, pe};
  wire [3:0]  rx_k    = rx_idx - 4'd1;
  wire        rx_mid  = rx_act && tick && rx_sub == 4'd7;
  wire        rx_stop = rx_mid && rx_idx != 4'd0 && rx_k == stop_k;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_act <= 1'b0; rx_sub <= '0; rx_idx <= '0; rx_buf <= '0; rx_pb <= 1'b0;
      r_flag <= 1'b0; fresh <= 1'b0; rx_data <= '0; rx_par <= 1'b0; rx_fe <= 1'b0;
    end else begin
      if (!rx_act) begin
        if (tick && !rxs) begin
          rx_act <= 1'b1; rx_sub <= '0; rx_idx <= '0; rx_buf <= '0; rx_pb <= 1'b0;
        end
      end else if (tick) begin
        rx_sub <= rx_sub + 4'd1;
        if (rx_sub == 4'd7) begin
          rx_idx <= rx_idx + 4'd1;
          if (rx_idx == 4'd0) begin
            if (rxs) rx_act <= 1'b0;
          end else if (rx_stop) rx_act <= 1'b0;
          else if (rx_k < nd) rx_buf[rx_k[2:0]] <= rxs;
          else rx_pb <= rxs;
        end
      end
      if (rx_stop) begin
        r_flag <= 1'b1; fresh <= 1'b1;
        rx_data <= rx_buf; rx_par <= rx_pb; rx_fe <= ~rxs;
      end else begin
        if (cs_fall) fresh <= 1'b0;
        if (rd_ack && !fresh) r_flag <= 1'b0;
      end
    end
endmodule

// File: rtl/spi_uart_chk.sv
module spi_uart_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        txd,
  input logic        rts_n,
  input logic [13:0] cfg,
  input logic        r_flag,
  input logic        thr_full,
  input logic        tx_busy,
  input logic        frame_ok,
  input logic        rx_stop
);
  assert_tx_start_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);

  assert_cfg_on_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg != $past(cfg)) |-> $past(frame_ok));

  assert_rts_on_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_n != $past(rts_n)) |-> $past(frame_ok));

  assert_flag_on_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_flag) |-> $past(rx_stop));

  assert_handoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_full && !tx_busy) |=> !thr_full);
endmodule

bind spi_uart spi_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .rts_n(rts_n), .cfg(cfg),
  .r_flag(r_flag), .thr_full(thr_full), .tx_busy(tx_busy),
  .frame_ok(frame_ok), .rx_stop(rx_stop)
);

// File: tb/tb_spi_uart.sv
`timescale 1ns/1ps
module tb_spi_uart;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic rxd = 1'b1, cts_n = 1'b1;
  wire  miso, txd, rts_n;

  always #2.5 clk = ~clk;

  spi_uart dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
                .miso(miso), .txd(txd), .rxd(rxd), .rts_n(rts_n), .cts_n(cts_n));

  int checks = 0, fails = 0, cyc = 0, hold_until = 0, rts_bad = 0;
  logic exp_rts = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;
  // clock-by-clock model of the request-to-send pin (R5)
  always @(negedge clk)
    if (rst_n && cyc > hold_until && rts_n !== exp_rts) rts_bad <= rts_bad + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic xfer(input logic [15:0] w, input int n, output logic [15:0] r);
    r = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = w[15-i];
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      r = {r[14:0], miso};
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    if (n == 16 && w[15:14] == 2'b10) begin
      exp_rts = ~w[9];
      hold_until = cyc + 10;
    end
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [15:0] fbits(input logic [8:0] d, input int nd, input bit pe, input bit st2);
    logic [15:0] b = '1;
    int k = 1;
    b[0] = 1'b0;
    for (int i = 0; i < nd; i++) begin b[k] = d[i]; k++; end
    if (pe) begin b[k] = d[8]; k++; end
    return b;
  endfunction

  function automatic int flen(input int nd, input bit pe, input bit st2);
    return 2 + nd + int'(pe) + int'(st2);
  endfunction

  task automatic cap(input int n, input int bc, output logic [15:0] g);
    g = '1;
    wait (txd === 1'b0);
    repeat (bc/2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      g[i] = txd;
      if (i < n-1) repeat (bc) @(negedge clk);
    end
  endtask

  task automatic send(input logic [8:0] d, input int nd, input bit pe, input int bc, input bit bad_stop);
    @(negedge clk); rxd = 1'b0; repeat (bc) @(negedge clk);
    for (int i = 0; i < nd; i++) begin rxd = d[i]; repeat (bc) @(negedge clk); end
    if (pe) begin rxd = d[8]; repeat (bc) @(negedge clk); end
    if (bad_stop) begin rxd = 1'b0; repeat (10) @(negedge clk); end
    rxd = 1'b1;
    repeat (bc*2) @(negedge clk);
  endtask

  task automatic measure(input logic [3:0] code, input int exp, input string req);
    logic [15:0] r;
    int n;
    xfer(16'hC000 | {12'd0, code}, 16, r);
    n = 0;
    fork
      begin
        wait (txd === 1'b0);
        wait (txd === 1'b1);
        while (txd === 1'b1) begin @(posedge clk); #1; n++; end
      end
      xfer(16'h8001, 16, r);
    join
    chk(n == exp, req, n, exp);
    repeat (exp * 12) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] r, g, g2, e;
    int lows;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    chk(txd === 1'b1 && rts_n === 1'b1, "R11 idle pins", {txd, rts_n}, 2'b11);
    xfer(16'h4000, 16, r);
    chk(r[13:0] == 14'd0, "R11 setup zero", r[13:0], 0);
    chk(r[15:14] == 2'b01, "R3 reset flags", r[15:14], 2'b01);

    // R2 setup write and readback; reads do not modify
    xfer(16'hC000 | 16'h3F80, 16, r);
    xfer(16'h7FFF, 16, r);
    chk(r[13:0] == 14'h3F80, "R2 readback", r[13:0], 14'h3F80);
    // R1 short frame ignored
    xfer(16'hFFFF, 8, r);
    xfer(16'h4000, 16, r);
    chk(r[13:0] == 14'h3F80, "R1 short frame ignored", r[13:0], 14'h3F80);
    xfer(16'hC000, 16, r);

    // R9 / R4 8N1 transmit
    fork
      cap(10, 16, g);
      xfer(16'h80A5, 16, r);
    join
    e = fbits(9'h0A5, 8, 0, 0);
    chk(g[9:0] == e[9:0], "R9 frame 8N1", g[9:0], e[9:0]);
    chk(r[14] == 1'b1, "R3 holding empty", r[14], 1);
    repeat (40) @(negedge clk);

    // R5 RTS and R4 disabled transmit
    xfer(16'h8633, 16, r);
    lows = 0;
    repeat (400) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    chk(rts_n === 1'b0, "R5 rts asserted", rts_n, 0);
    chk(lows == 0, "R4 disabled write not sent", lows, 0);
    xfer(16'h8400, 16, r);
    chk(rts_n === 1'b1, "R5 rts released", rts_n, 1);

    // R6 / R7 receive and clear
    send(9'h03C, 8, 0, 16, 0);
    xfer(16'h0000, 16, r);
    chk(r[15] == 1'b1 && r[7:0] == 8'h3C, "R6 rx byte", r, 16'h803C);
    chk(r[13:8] == 6'd0, "R6 status bits clear", r[13:8], 0);
    xfer(16'h0000, 16, r);
    chk(r[15] == 1'b0, "R7 flag cleared", r[15], 0);
    cts_n = 1'b0;
    repeat (4) @(negedge clk);
    xfer(16'h0000, 16, r);
    chk(r[9] == 1'b1, "R6 cts reported", r[9], 1);
    cts_n = 1'b1;

    // R10 framing error
    send(9'h081, 8, 0, 16, 1);
    xfer(16'h0000, 16, r);
    chk(r[15] == 1'b1 && r[10] == 1'b1 && r[7:0] == 8'h81, "R10 framing error", r, 16'h8481);

    // R7 overwrite
    send(9'h011, 8, 0, 16, 0);
    send(9'h022, 8, 0, 16, 0);
    xfer(16'h0000, 16, r);
    chk(r[15] == 1'b1 && r[7:0] == 8'h22 && r[10] == 1'b0, "R7 overwrite", r, 16'hC022);
    xfer(16'h0000, 16, r);
    chk(r[15] == 1'b0, "R7 single read empties", r[15], 0);

    // R4 data write returns pending byte, R7 clears
    send(9'h05A, 8, 0, 16, 0);
    xfer(16'h8400, 16, r);
    chk(r[15] == 1'b1 && r[7:0] == 8'h5A, "R4 write returns byte", r, 16'hC05A);
    xfer(16'h0000, 16, r);
    chk(r[15] == 1'b0, "R7 cleared by write", r[15], 0);

    // R9 / R6 seven bits, extra bit, two stops
    xfer(16'hC070, 16, r);
    fork
      cap(11, 16, g);
      xfer(16'h8155, 16, r);
    join
    e = fbits(9'h155, 7, 1, 1);
    chk(g[10:0] == e[10:0] && flen(7, 1, 1) == 11, "R9 frame 7E2", g[10:0], e[10:0]);
    repeat (40) @(negedge clk);
    send(9'h12B, 7, 1, 16, 0);
    xfer(16'h0000, 16, r);
    chk(r[7:0] == 8'h2B && r[8] == 1'b1, "R6 extra bit received", r[8:0], 9'h12B);

    // R8 bit times
    measure(4'd1, 32, "R8 code1");
    measure(4'd5, 32, "R8 code5 fallback");
    measure(4'd9, 96, "R8 code9");

    // R4 full holding register drops a write (divider 4)
    xfer(16'hC002, 16, r);
    fork
      begin cap(10, 64, g); cap(10, 64, g2); end
      begin
        xfer(16'h8041, 16, r);
        xfer(16'h8042, 16, r);
        xfer(16'h8043, 16, r);
        chk(r[14] == 1'b0, "R3 holding full flag", r[14], 0);
      end
    join
    chk(g[7:0] == 8'h82 && g2[7:0] == 8'h84, "R4 two queued bytes", {g[7:0], g2[7:0]}, 16'h8284);
    lows = 0;
    repeat (1000) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    chk(lows == 0, "R4 write to full register dropped", lows, 0);

    chk(rts_bad == 0, "R5 rts model per clock", rts_bad, 0);
    summary();
    $finish;
  end
endmodule